// File: doc/BRIEF.md
# Per-Subpage ECC Status Aggregator

This block sits behind a symbol-correcting ECC decoder on a flash page path. The decoder reports one 4-bit error count for each 512-byte slice of a page. The block records each report in its own nibble of a packed status word. It also keeps a running total of corrected symbols and a sticky uncorrectable flag. A page opens with a start pulse, takes one report per strobe and closes with a done pulse. After the done pulse the summary is marked valid and stays frozen until the next start.

The decode rules follow a mode input. Four-symbol and eight-symbol strengths differ in how many bits of a count are meaningful and in the correction limit. An automatic setting picks the strength from the spare-area density. A single-bit mode reads each report as two 2-bit codes. A combinational output shows which strength the spare density supports, so the same logic can set up the decoder.

Top module: `ecc_stat_agg`

## Requirements
- R1: `page_sel_i` sets how many reports a page accepts: 0 accepts 1, 1 accepts 4, and 2 or 3 accept 8. Reports beyond that number change no output.
- R2: The k-th accepted report since start (k from 0) is written to `status_o[4k+3:4k]`. Nibbles with no report read zero.
- R3: In mode 0 (four-symbol), only bits [2:0] of a count are used, and the stored nibble is that 3-bit value. The limit is 4.
- R4: In mode 1 (eight-symbol), all 4 bits of a count are used and the limit is 8.
- R5: A count above the limit sets `uncorr_o`, which stays set until the next start, and it adds nothing to `total_o`. A count at or below the limit is added to `total_o`, which never decreases within a page.
- R6: `strength8_o` is 1 when `spare_bytes_i` shifted right by 0, 2 or 3 bits is at least 26. The shift is 0 for `page_sel_i` = 0, 2 for `page_sel_i` = 1, and 3 otherwise. In mode 2 (automatic), reports are decoded as mode 1 when `strength8_o` is 1 and as mode 0 when it is 0.
- R7: In mode 3 (single-bit), bits [1:0] and bits [3:2] are separate codes. Code 2 makes the report uncorrectable, code 1 counts one corrected bit, and codes 0 and 3 count nothing. An uncorrectable report adds nothing to the total. The nibble is stored as received.
- R8: A `start_i` pulse clears `status_o`, `total_o`, `uncorr_o` and `valid_o` on the next edge. A report strobed in the same cycle as `start_i` becomes report 0 of the new page. A `done_i` in that cycle is ignored.
- R9: `done_i` raises `valid_o` on the next edge. A report strobed in the same cycle as `done_i` is included in the summary.
- R10: While `valid_o` is high, reports and further `done_i` pulses leave every output unchanged until `start_i`.
- R11: During reset, `status_o`, `total_o`, `uncorr_o` and `valid_o` are zero. Outputs update on the rising edge after the cycle in which a report is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_sel_i | input | 2 | Page size: 0 = 512, 1 = 2048, 2/3 = 4096 bytes |
| mode_i | input | 2 | 0 four-symbol, 1 eight-symbol, 2 automatic, 3 single-bit |
| spare_bytes_i | input | 8 | Spare bytes per page |
| start_i | input | 1 | Opens a new page |
| done_i | input | 1 | Closes the page |
| err_valid_i | input | 1 | Report strobe |
| err_cnt_i | input | 4 | Per-subpage error report |
| status_o | output | 32 | Packed per-subpage nibbles |
| total_o | output | 7 | Corrected symbol (or bit) total |
| uncorr_o | output | 1 | Some subpage was uncorrectable |
| valid_o | output | 1 | Summary complete |
| strength8_o | output | 1 | Spare density supports eight-symbol strength |

## Verification
A report strobe can coincide with either page boundary. It can arrive with the start of a new page, where it must land in nibble 0 of a cleared word. It can also arrive with the done pulse, where it must be counted before the summary freezes. The bench drives both coincidences directly. For the first, it checks that the earlier page's contents are gone and that the new report appears alone in slot 0 with its count as the total. For the second, it checks that the closing report is in the top accepted nibble and in the total once `valid_o` rises, and that a report sent after that point changes nothing.

// File: rtl/ecc_agg_pkg.sv
package ecc_agg_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [1:0] {
    MODE_SYM4 = 2'd0,
    MODE_SYM8 = 2'd1,
    MODE_AUTO = 2'd2,
    MODE_BIT1 = 2'd3
  } ecc_mode_e;

  typedef enum logic [1:0] {
    PG_512  = 2'd0,
    PG_2K   = 2'd1,
    PG_4K   = 2'd2,
    PG_4K_A = 2'd3
  } page_sel_e;
endpackage

// File: rtl/ecc_strength_sel.sv
module ecc_strength_sel
  import ecc_agg_pkg::*;
#(
  parameter int SPARE_W = 8,
  parameter int MIN_SP8 = 26
) (
  input  logic [1:0]         page_sel_i,
  input  logic [SPARE_W-1:0] spare_bytes_i,
  output logic               strength8_o
);
  logic [SPARE_W-1:0] per_512;

  // spare bytes per 512 data bytes
  always_comb begin
    unique case (page_sel_e'(page_sel_i))
      PG_512:  per_512 = spare_bytes_i;
      PG_2K:   per_512 = spare_bytes_i >> 2;
      default: per_512 = spare_bytes_i >> 3;
    endcase
  end

  assign strength8_o = (32'(per_512) >= MIN_SP8);
endmodule

// File: rtl/ecc_field_eval.sv
module ecc_field_eval
  import ecc_agg_pkg::*;
#(
  parameter int LIM4 = 4,
  parameter int LIM8 = 8
) (
  input  ecc_mode_e          mode_i,
  input  logic [FIELD_W-1:0] cnt_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [FIELD_W-1:0] add_o,
  output logic               uncorr_o
);
  logic [1:0] code_lo, code_hi;
  logic [FIELD_W-1:0] bit_add;

  assign code_lo = cnt_i[1:0];
  assign code_hi = cnt_i[3:2];
  assign bit_add = FIELD_W'(code_lo == 2'd1) + FIELD_W'(code_hi == 2'd1);

  always_comb begin
    field_o  = cnt_i;
    uncorr_o = 1'b0;
    unique case (mode_i)
      MODE_SYM4: begin
        field_o  = {1'b0, cnt_i[2:0]};
        uncorr_o = 32'(field_o) > LIM4;
      end
      MODE_BIT1: begin
        uncorr_o = (code_lo == 2'd2) || (code_hi == 2'd2);
      end
      default: begin
        uncorr_o = 32'(cnt_i) > LIM8;
      end
    endcase
    if (uncorr_o)                add_o = '0;
    else if (mode_i == MODE_BIT1) add_o = bit_add;
    else                          add_o = field_o;
  end
endmodule

// File: rtl/ecc_page_acc.sv
module ecc_page_acc
  import ecc_agg_pkg::*;
#(
  parameter int MAX_SUB = 8,
  parameter int TOT_W   = 7,
  localparam int IDX_W  = $clog2(MAX_SUB) + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       done_i,
  input  logic                       rep_valid_i,
  input  logic [IDX_W-1:0]           num_sub_i,
  input  logic [FIELD_W-1:0]         field_i,
  input  logic [FIELD_W-1:0]         add_i,
  input  logic                       uncorr_i,
  output logic [MAX_SUB*FIELD_W-1:0] status_o,
  output logic [TOT_W-1:0]           total_o,
  output logic                       uncorr_o,
  output logic                       valid_o
);
  logic [IDX_W-1:0] idx_q;
  logic [TOT_W-1:0] tot_q;
  logic             unc_q, done_q;
  logic             take;

  // a start always opens slot 0, so the report riding with it is taken
  assign take = rep_valid_i && (start_i || (!done_q && (idx_q < num_sub_i)));

  for (genvar k = 0; k < MAX_SUB; k++) begin : g_slot
    logic [FIELD_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q <= '0;
      else if (start_i)                             slot_q <= (take && k == 0) ? field_i : '0;
      else if (take && idx_q == IDX_W'(k))          slot_q <= field_i;
    end
    assign status_o[k*FIELD_W +: FIELD_W] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      tot_q  <= '0;
      unc_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= take ? IDX_W'(1) : '0;
      tot_q  <= take ? TOT_W'(add_i) : '0;
      unc_q  <= take && uncorr_i;
      done_q <= 1'b0;
    end else begin
      if (take) begin
        idx_q <= idx_q + 1'b1;
        tot_q <= tot_q + TOT_W'(add_i);
        unc_q <= unc_q | uncorr_i;
      end
      if (done_i) done_q <= 1'b1;
    end
  end

  assign total_o  = tot_q;
  assign uncorr_o = unc_q;
  assign valid_o  = done_q;
endmodule

// File: rtl/ecc_stat_agg.sv
module ecc_stat_agg
  import ecc_agg_pkg::*;
#(
  parameter int MAX_SUB = 8,
  parameter int SPARE_W = 8,
  parameter int MIN_SP8 = 26,
  parameter int LIM4    = 4,
  parameter int LIM8    = 8,
  localparam int STAT_W = MAX_SUB * FIELD_W,
  localparam int TOT_W  = $clog2(MAX_SUB * LIM8 + 1),
  localparam int IDX_W  = $clog2(MAX_SUB) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         page_sel_i,
  input  logic [1:0]         mode_i,
  input  logic [SPARE_W-1:0] spare_bytes_i,
  input  logic               start_i,
  input  logic               done_i,
  input  logic               err_valid_i,
  input  logic [FIELD_W-1:0] err_cnt_i,
  output logic [STAT_W-1:0]  status_o,
  output logic [TOT_W-1:0]   total_o,
  output logic               uncorr_o,
  output logic               valid_o,
  output logic               strength8_o
);
  localparam int SUB_MID = (MAX_SUB >= 4) ? 4 : MAX_SUB;

  logic [IDX_W-1:0]   num_sub;
  ecc_mode_e          eff_mode;
  logic [FIELD_W-1:0] field, add;
  logic               rep_unc;

  always_comb begin
    unique case (page_sel_e'(page_sel_i))
      PG_512:  num_sub = IDX_W'(1);
      PG_2K:   num_sub = IDX_W'(SUB_MID);
      default: num_sub = IDX_W'(MAX_SUB);
    endcase
  end

  always_comb begin
    eff_mode = ecc_mode_e'(mode_i);
    if (eff_mode == MODE_AUTO) eff_mode = strength8_o ? MODE_SYM8 : MODE_SYM4;
  end

  ecc_strength_sel #(.SPARE_W(SPARE_W), .MIN_SP8(MIN_SP8)) i_sel (
    .page_sel_i   (page_sel_i),
    .spare_bytes_i(spare_bytes_i),
    .strength8_o  (strength8_o)
  );

  ecc_field_eval #(.LIM4(LIM4), .LIM8(LIM8)) i_eval (
    .mode_i  (eff_mode),
    .cnt_i   (err_cnt_i),
    .field_o (field),
    .add_o   (add),
    .uncorr_o(rep_unc)
  );

  ecc_page_acc #(.MAX_SUB(MAX_SUB), .TOT_W(TOT_W)) i_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .done_i     (done_i),
    .rep_valid_i(err_valid_i),
    .num_sub_i  (num_sub),
    .field_i    (field),
    .add_i      (add),
    .uncorr_i   (rep_unc),
    .status_o   (status_o),
    .total_o    (total_o),
    .uncorr_o   (uncorr_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/ecc_stat_agg_chk.sv
module ecc_stat_agg_chk #(
  parameter int STAT_W  = 32,
  parameter int TOT_W   = 7,
  parameter int SPARE_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         page_sel_i,
  input logic [1:0]         mode_i,
  input logic [SPARE_W-1:0] spare_bytes_i,
  input logic               start_i,
  input logic               done_i,
  input logic               err_valid_i,
  input logic [3:0]         err_cnt_i,
  input logic [STAT_W-1:0]  status_o,
  input logic [TOT_W-1:0]   total_o,
  input logic               uncorr_o,
  input logic               valid_o,
  input logic               strength8_o
);
  p_start_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !err_valid_i |=> status_o == '0 && total_o == '0 && !uncorr_o && !valid_o);

  p_done_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !start_i |=> valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !start_i |=> valid_o && $stable(status_o) && $stable(total_o) && $stable(uncorr_o));

  p_unc_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o && !start_i |=> uncorr_o);

  p_tot_mono_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> total_o >= $past(total_o));

  p_sym4_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && mode_i == 2'd0 |=> total_o - $past(total_o) <= TOT_W'(4));

  p_bit1_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && mode_i == 2'd3 |=> total_o - $past(total_o) <= TOT_W'(2));
endmodule

bind ecc_stat_agg ecc_stat_agg_chk #(
  .STAT_W(STAT_W), .TOT_W(TOT_W), .SPARE_W(SPARE_W)
) i_chk (.*);

// File: tb/test_ecc_stat_agg.sv
module test_ecc_stat_agg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  page_sel_i = '0, mode_i = '0;
  logic [7:0]  spare_bytes_i = '0;
  logic        start_i = 1'b0, done_i = 1'b0, err_valid_i = 1'b0;
  logic [3:0]  err_cnt_i = '0;
  logic [31:0] status_o;
  logic [6:0]  total_o;
  logic        uncorr_o, valid_o, strength8_o;

  int total = 0, bad = 0;
  bit fin = 1'b0;

  always #5 clk_i = ~clk_i;

  ecc_stat_agg i_ecc_stat_agg (.*);

  typedef struct packed {
    logic [1:0]  pg;
    logic [1:0]  md;
    logic [7:0]  sp;
    logic [3:0]  n;
    logic [31:0] cnts;
    logic [31:0] st;
    logic [6:0]  tot;
    logic        unc;
    logic        s8;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 8'd16,  4'd1, 32'h0000_0003, 32'h0000_0003, 7'd3,  1'b0, 1'b0}, // R3
    '{2'd0, 2'd0, 8'd16,  4'd1, 32'h0000_000D, 32'h0000_0005, 7'd0,  1'b1, 1'b0}, // R3 R5
    '{2'd1, 2'd1, 8'd64,  4'd4, 32'h0000_9812, 32'h0000_9812, 7'd11, 1'b1, 1'b0}, // R4 R5
    '{2'd1, 2'd1, 8'd64,  4'd6, 32'h0077_4321, 32'h0000_4321, 7'd10, 1'b0, 1'b0}, // R1 R2
    '{2'd2, 2'd2, 8'd128, 4'd8, 32'h8765_4321, 32'h0765_4321, 7'd10, 1'b1, 1'b0}, // R6
    '{2'd2, 2'd2, 8'd224, 4'd8, 32'h8765_4321, 32'h8765_4321, 7'd36, 1'b0, 1'b1}, // R6
    '{2'd1, 2'd2, 8'd104, 4'd4, 32'h0000_8D00, 32'h0000_8D00, 7'd8,  1'b1, 1'b1}, // R6
    '{2'd1, 2'd3, 8'd0,   4'd4, 32'h0000_4935, 32'h0000_4935, 7'd3,  1'b1, 1'b0}, // R7
    '{2'd0, 2'd3, 8'd26,  4'd1, 32'h0000_0001, 32'h0000_0001, 7'd1,  1'b0, 1'b1}  // R7 R6
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic dn, input logic v, input logic [3:0] c);
    @(negedge clk_i);
    start_i = st; done_i = dn; err_valid_i = v; err_cnt_i = c;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, 4'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 status", status_o, 32'h0);
    chk("R11 total", 32'(total_o), 32'd0);
    chk("R11 uncorr", 32'(uncorr_o), 32'd0);
    chk("R11 valid", 32'(valid_o), 32'd0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      page_sel_i = VECS[v].pg; mode_i = VECS[v].md; spare_bytes_i = VECS[v].sp;
      cyc(1'b1, 1'b0, 1'b0, 4'd0);
      for (int k = 0; k < int'(VECS[v].n); k++) cyc(1'b0, 1'b0, 1'b1, VECS[v].cnts[4*k +: 4]);
      cyc(1'b0, 1'b1, 1'b0, 4'd0);
      idle();
      chk($sformatf("R2 vec%0d status", v), status_o, VECS[v].st);
      chk($sformatf("R5 vec%0d total", v), 32'(total_o), 32'(VECS[v].tot));
      chk($sformatf("R5 vec%0d uncorr", v), 32'(uncorr_o), 32'(VECS[v].unc));
      chk($sformatf("R9 vec%0d valid", v), 32'(valid_o), 32'd1);
      chk($sformatf("R6 vec%0d strength8", v), 32'(strength8_o), 32'(VECS[v].s8));
    end

    // R8: plain start clears a non-empty, flagged summary
    cyc(1'b1, 1'b0, 1'b0, 4'd0);
    idle();
    chk("R8 clear status", status_o, 32'h0);
    chk("R8 clear total", 32'(total_o), 32'd0);
    chk("R8 clear valid", 32'(valid_o), 32'd0);

    // R8: report with start lands in slot 0
    page_sel_i = 2'd1; mode_i = 2'd1; spare_bytes_i = 8'd64;
    cyc(1'b0, 1'b0, 1'b1, 4'd9);
    cyc(1'b0, 1'b1, 1'b0, 4'd0);
    cyc(1'b1, 1'b0, 1'b1, 4'd5);
    cyc(1'b0, 1'b0, 1'b1, 4'd2);
    idle();
    chk("R8 same-cycle status", status_o, 32'h0000_0025);
    chk("R8 same-cycle total", 32'(total_o), 32'd7);
    chk("R8 same-cycle uncorr", 32'(uncorr_o), 32'd0);

    // R9: closing report rides with done
    cyc(1'b1, 1'b0, 1'b0, 4'd0);
    cyc(1'b0, 1'b0, 1'b1, 4'd1);
    cyc(1'b0, 1'b0, 1'b1, 4'd1);
    cyc(1'b0, 1'b0, 1'b1, 4'd1);
    cyc(1'b0, 1'b1, 1'b1, 4'd3);
    idle();
    chk("R9 with-done status", status_o, 32'h0000_3111);
    chk("R9 with-done total", 32'(total_o), 32'd6);
    chk("R9 with-done valid", 32'(valid_o), 32'd1);

    // R10: late report after done is ignored (a slot would still be free on 4K)
    page_sel_i = 2'd2;
    cyc(1'b0, 1'b0, 1'b1, 4'd7);
    cyc(1'b0, 1'b1, 1'b1, 4'd9);
    idle();
    chk("R10 hold status", status_o, 32'h0000_3111);
    chk("R10 hold total", 32'(total_o), 32'd6);
    chk("R10 hold uncorr", 32'(uncorr_o), 32'd0);

    // R1: before done, extra report on 512 page is dropped
    page_sel_i = 2'd0; mode_i = 2'd1;
    cyc(1'b1, 1'b0, 1'b0, 4'd0);
    cyc(1'b0, 1'b0, 1'b1, 4'd4);
    cyc(1'b0, 1'b0, 1'b1, 4'd6);
    idle();
    chk("R1 single slot status", status_o, 32'h0000_0004);
    chk("R1 single slot total", 32'(total_o), 32'd4);
    chk("R1 single slot valid", 32'(valid_o), 32'd0);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule